// File: doc/BRIEF.md
# Fractional Period Tick Generator

This block emits a stream of single-cycle tick pulses whose long-run spacing equals a programmable fixed-point period. The period word has a 10-bit whole part and a 9-bit fraction. The whole part is loaded into a down-counter. That counter steps once per input clock, which is a time-base enable taken either as it is or divided by two. Each time the counter completes, a tick is issued and the fraction is added into a 9-bit accumulator. When that addition carries, the counter pauses for one input clock. Over many ticks, the spacing therefore averages to the whole part plus the fraction over 512.

A second mode, requested by a level input, ignores the time base and produces a tick every eight system clocks. On entry to this mode the counter is first preloaded to a full eight-clock span. This keeps the first fast tick at least eight clocks away from the last slow one. A write of the period word and a tooth-advance strobe each clear the accumulator, so that the fraction pattern restarts from a known phase.

Top module: `frac_tick_gen`

## Requirements
- R1: After an accumulator clear, the N ticks that follow the first tick span exactly N*W + floor(N*F/512) input clocks. W is the effective whole part and F is the 9-bit fraction (bits 8:0 of the period word). Each carry from the 9-bit addition delays the next tick by exactly one input clock.
- R2: With `div2_i` low, every cycle with `tb_en_i` high is an input clock. With `div2_i` high, only every second such cycle is an input clock.
- R3: A whole part of zero (bits 18:9 of the period word) behaves exactly as a whole part of one. The down-counter never holds zero.
- R4: A period write does not disturb the count in progress. The new whole part is used from the next reload onward. The write also clears the accumulator.
- R5: A pulse on `tooth_adv_i` clears the accumulator, so the next fraction addition starts from zero.
- R6: `tick_o` is a registered pulse. In normal mode it is high only in the system clock after an input clock that completes the count.
- R7: While in high-rate mode, consecutive ticks are exactly 8 system clocks apart, whatever `tb_en_i` does. No fraction additions take place in this mode.
- R8: On the cycle that high-rate mode is entered, the counter is preloaded to 8. The first high-rate tick follows 8 system clocks later, and any pending pause is dropped.
- R9: On leaving high-rate mode, the counter reloads the full effective whole part and any pending pause is dropped. The next tick follows that many input clocks later.
- R10: In reset, `tick_o` is low, the accumulator is zero, the mode is normal and the counter holds the reset whole part (4). With a steady enable, the first tick appears 4 clocks after reset is released.
- R11: The full-scale whole part 1023 with fraction 511 follows R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | 19 | Period word: whole part in bits 18:9, fraction in bits 8:0 |
| period_wr_i | input | 1 | Captures `period_i` and clears the accumulator |
| tooth_adv_i | input | 1 | Clears the accumulator |
| tb_en_i | input | 1 | Time-base enable |
| div2_i | input | 1 | Selects one input clock per two enables |
| high_rate_i | input | 1 | Level request for the fixed eight-clock tick mode |
| tick_o | output | 1 | One-cycle tick pulse |

## Verification
The bench sweeps whole parts from 0 to 5 against fractions chosen around the carry boundaries (0, 1, 256, 257, 511 and others). It checks tick spans exactly over 32 ticks. A design that dropped or doubled the carry pause, or let zero underflow the counter, would be off by one or more clocks. Further runs repeat the span check with the divide-by-two select and a sparse enable, and once more at full scale.

Targeted sequences cover the remaining behaviour:
- A mid-interval write must leave the running interval alone, which catches a design that reloads at once.
- A tooth pulse between two ticks must shift the carry pattern, which catches a missing clear.
- The high-rate run checks a 9-cycle entry gap and an 8-cycle cadence with the enable removed.
- The exit sequence checks a carry pattern that would flip if high-rate ticks had fed the accumulator.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

    localparam int unsigned DEF_INT_W  = 10;
    localparam int unsigned DEF_FRAC_W = 9;
    localparam int unsigned DEF_HR_DIV = 8;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_HIGH   = 1'b1
    } mode_e;

    typedef struct packed {
        logic fire;
        logic load;
    } pulse_t;

    // Replaces a zero count by one so the counter never holds zero.
    function automatic int unsigned nonzero(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/ftg_ce_div.sv
module ftg_ce_div (
    input  logic clk,
    input  logic rst,
    input  logic tb_en_i,
    input  logic div2_i,
    output logic ce_o
);

    logic ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= 1'b0;
        end else if (tb_en_i) begin
            ph_q <= ~ph_q;
        end
    end

    // With the halving select, only the enable seen while ph_q is set counts.
    assign ce_o = tb_en_i & (~div2_i | ph_q);

endmodule

// File: rtl/ftg_frac_acc.sv
module ftg_frac_acc #(
    parameter int unsigned FRAC_W = ftg_pkg::DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              load_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              carry_o,
    output logic [FRAC_W-1:0] acc_o
);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, frac_i};

    // A clear in the same cycle as a load wins and discards that carry.
    assign carry_o = load_i & sum[FRAC_W] & ~clear_i;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            acc_q <= '0;
        end else if (load_i) begin
            acc_q <= sum[FRAC_W-1:0];
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/ftg_prescaler.sv
module ftg_prescaler
    import ftg_pkg::*;
#(
    parameter int unsigned INT_W   = DEF_INT_W,
    parameter int unsigned HR_DIV  = DEF_HR_DIV,
    parameter int unsigned RST_CNT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_i,
    input  logic             high_rate_i,
    input  logic [INT_W-1:0] reload_i,
    input  logic             carry_i,
    output pulse_t           pulse_o,
    output logic [INT_W-1:0] cnt_o,
    output logic             stall_o,
    output mode_e            mode_o
);

    localparam logic [INT_W-1:0] HR_LOAD  = INT_W'(HR_DIV);
    localparam logic [INT_W-1:0] RST_LOAD = INT_W'(nonzero(RST_CNT));

    logic [INT_W-1:0] cnt_q, cnt_d;
    logic             stall_q, stall_d;
    mode_e            mode_q, mode_d;
    logic             enter, leave;
    pulse_t           pulse;

    assign enter = (mode_q == MODE_NORMAL) &&  high_rate_i;
    assign leave = (mode_q == MODE_HIGH)   && !high_rate_i;

    always_comb begin
        cnt_d      = cnt_q;
        stall_d    = stall_q;
        mode_d     = mode_q;
        pulse.fire = 1'b0;
        pulse.load = 1'b0;
        if (enter) begin
            cnt_d   = HR_LOAD;
            stall_d = 1'b0;
            mode_d  = MODE_HIGH;
        end else if (leave) begin
            cnt_d   = reload_i;
            stall_d = 1'b0;
            mode_d  = MODE_NORMAL;
        end else if (mode_q == MODE_HIGH) begin
            if (cnt_q == 1) begin
                pulse.fire = 1'b1;
                cnt_d      = HR_LOAD;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end else if (ce_i) begin
            if (stall_q) begin
                stall_d = 1'b0;
            end else if (cnt_q == 1) begin
                pulse.fire = 1'b1;
                pulse.load = 1'b1;
                cnt_d      = reload_i;
                stall_d    = carry_i;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= RST_LOAD;
            stall_q <= 1'b0;
            mode_q  <= MODE_NORMAL;
        end else begin
            cnt_q   <= cnt_d;
            stall_q <= stall_d;
            mode_q  <= mode_d;
        end
    end

    assign pulse_o = pulse;
    assign cnt_o   = cnt_q;
    assign stall_o = stall_q;
    assign mode_o  = mode_q;

endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
    import ftg_pkg::*;
#(
    parameter int unsigned INT_W     = DEF_INT_W,
    parameter int unsigned FRAC_W    = DEF_FRAC_W,
    parameter int unsigned HR_DIV    = DEF_HR_DIV,
    parameter int unsigned RST_WHOLE = 4,
    parameter int unsigned RST_FRAC  = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [INT_W+FRAC_W-1:0] period_i,
    input  logic                    period_wr_i,
    input  logic                    tooth_adv_i,
    input  logic                    tb_en_i,
    input  logic                    div2_i,
    input  logic                    high_rate_i,
    output logic                    tick_o
);

    localparam int unsigned PW = INT_W + FRAC_W;
    localparam logic [PW-1:0] RST_WORD =
        {INT_W'(RST_WHOLE), FRAC_W'(RST_FRAC)};

    logic [PW-1:0]     period_q;
    logic [INT_W-1:0]  whole;
    logic [INT_W-1:0]  reload;
    logic [FRAC_W-1:0] frac;
    logic              in_ce;
    logic              carry;
    logic              acc_clear;
    logic [FRAC_W-1:0] acc_val;
    logic [INT_W-1:0]  cnt_val;
    logic              stall_val;
    logic              hr_active;
    mode_e             mode;
    pulse_t            pulse;
    logic              tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= RST_WORD;
        end else if (period_wr_i) begin
            period_q <= period_i;
        end
    end

    assign whole     = period_q[PW-1:FRAC_W];
    assign frac      = period_q[FRAC_W-1:0];
    assign reload    = (whole == '0) ? INT_W'(1) : whole;
    assign acc_clear = period_wr_i | tooth_adv_i;
    assign hr_active = (mode == MODE_HIGH);

    ftg_ce_div u_ce (
        .clk     (clk),
        .rst     (rst),
        .tb_en_i (tb_en_i),
        .div2_i  (div2_i),
        .ce_o    (in_ce)
    );

    ftg_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clear_i (acc_clear),
        .load_i  (pulse.load),
        .frac_i  (frac),
        .carry_o (carry),
        .acc_o   (acc_val)
    );

    ftg_prescaler #(
        .INT_W   (INT_W),
        .HR_DIV  (HR_DIV),
        .RST_CNT (RST_WHOLE)
    ) u_pre (
        .clk         (clk),
        .rst         (rst),
        .ce_i        (in_ce),
        .high_rate_i (high_rate_i),
        .reload_i    (reload),
        .carry_i     (carry),
        .pulse_o     (pulse),
        .cnt_o       (cnt_val),
        .stall_o     (stall_val),
        .mode_o      (mode)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= pulse.fire;
        end
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/frac_tick_chk.sv
module frac_tick_chk #(
    parameter int unsigned INT_W  = 10,
    parameter int unsigned FRAC_W = 9,
    parameter int unsigned HR_DIV = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_o,
    input logic              period_wr_i,
    input logic              tooth_adv_i,
    input logic              high_rate_i,
    input logic              in_ce,
    input logic              hr_active,
    input logic [INT_W-1:0]  cnt_val,
    input logic [FRAC_W-1:0] acc_val,
    input logic              stall_val
);

    p_cnt_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_val != '0);

    p_acc_cleared_r5: assert property (@(posedge clk) disable iff (rst)
        (tooth_adv_i || period_wr_i) |=> acc_val == '0);

    p_tick_after_ce_r6: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> $past(in_ce || hr_active));

    p_stall_one_clock_r1: assert property (@(posedge clk) disable iff (rst)
        (stall_val && in_ce && !hr_active && !high_rate_i)
            |=> (!stall_val && $stable(cnt_val)));

    p_hr_bounded_r7: assert property (@(posedge clk) disable iff (rst)
        hr_active |-> (cnt_val <= INT_W'(HR_DIV)));

    p_hr_entry_r8: assert property (@(posedge clk) disable iff (rst)
        (!hr_active && high_rate_i)
            |=> (hr_active && cnt_val == INT_W'(HR_DIV) && !stall_val));

    p_hr_exit_r9: assert property (@(posedge clk) disable iff (rst)
        (hr_active && !high_rate_i) |=> (!hr_active && !stall_val));

endmodule

bind frac_tick_gen frac_tick_chk #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W),
    .HR_DIV (HR_DIV)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_o      (tick_o),
    .period_wr_i (period_wr_i),
    .tooth_adv_i (tooth_adv_i),
    .high_rate_i (high_rate_i),
    .in_ce       (in_ce),
    .hr_active   (hr_active),
    .cnt_val     (cnt_val),
    .acc_val     (acc_val),
    .stall_val   (stall_val)
);

// File: tb/tb_frac_tick_gen.sv
module tb_frac_tick_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [18:0] period_i = '0;
    logic        period_wr_i = 1'b0;
    logic        tooth_adv_i = 1'b0;
    logic        tb_en_i = 1'b0;
    logic        div2_i = 1'b0;
    logic        high_rate_i = 1'b0;
    logic        tick_o;

    int n_checks = 0;
    int n_fail   = 0;
    int en_per   = 1;
    int en_ph    = 0;
    bit gate     = 1'b1;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    frac_tick_gen dut (
        .clk         (clk),
        .rst         (rst),
        .period_i    (period_i),
        .period_wr_i (period_wr_i),
        .tooth_adv_i (tooth_adv_i),
        .tb_en_i     (tb_en_i),
        .div2_i      (div2_i),
        .high_rate_i (high_rate_i),
        .tick_o      (tick_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One system clock: sample at the falling edge, then drive the next enable.
    task automatic step();
        @(negedge clk);
        tb_en_i = gate && (en_ph == 0);
        en_ph   = (en_ph + 1) % en_per;
    endtask

    task automatic wait_tick(output int cycles);
        cycles = 0;
        do begin
            step();
            cycles++;
        end while (!tick_o && cycles < 20000);
        if (!tick_o) begin
            n_fail++;
            $display("FAIL watchdog: no tick within %0d cycles", cycles);
        end
    endtask

    task automatic write_paused(input int whole, input int frac);
        gate = 1'b0;
        step();
        step();
        period_i    = {10'(whole), 9'(frac)};
        period_wr_i = 1'b1;
        step();
        period_wr_i = 1'b0;
        gate = 1'b1;
    endtask

    task automatic span(input string req, input int whole, input int frac,
                        input int per, input bit d2, input int n);
        int g;
        longint tot;
        longint wexp;
        en_per = per;
        en_ph  = 0;
        div2_i = d2;
        write_paused(whole, frac);
        wait_tick(g);
        tot = 0;
        for (int k = 0; k < n; k++) begin
            wait_tick(g);
            tot += g;
        end
        wexp = (whole == 0) ? 1 : whole;
        check(req, tot, longint'(per) * (d2 ? 2 : 1) *
              (longint'(n) * wexp + (longint'(n) * frac) / 512));
    endtask

    initial begin
        int g;
        int wl [5] = '{0, 1, 2, 3, 5};
        int fl [7] = '{0, 1, 127, 256, 257, 384, 511};

        // R10: reset state and first tick from the reset whole part
        gate = 1'b1;
        en_per = 1;
        repeat (4) step();
        check("R10 tick low in reset", tick_o, 0);
        rst = 1'b0;
        wait_tick(g);
        check("R10 first tick after reset", g, 4);

        // R1 and R3: sweep whole parts and fractions with a steady enable
        foreach (wl[i]) begin
            foreach (fl[j]) begin
                span(wl[i] == 0 ? "R3 zero whole part" : "R1 average period",
                     wl[i], fl[j], 1, 1'b0, 32);
            end
        end

        // R2: halving select and sparse enables
        span("R2 div2", 2, 0, 1, 1'b1, 32);
        span("R2 div2", 3, 300, 1, 1'b1, 32);
        span("R2 sparse enable", 2, 300, 3, 1'b0, 32);
        span("R2 sparse enable div2", 3, 77, 3, 1'b1, 32);

        // R11: full scale
        span("R11 full scale", 1023, 511, 1, 1'b0, 3);

        // R4: write during an interval applies at the next reload
        en_per = 1;
        div2_i = 1'b0;
        write_paused(10, 0);
        wait_tick(g);
        period_i    = {10'd3, 9'd0};
        period_wr_i = 1'b1;
        step();
        period_wr_i = 1'b0;
        wait_tick(g);
        check("R4 running interval kept", g + 1, 10);
        wait_tick(g);
        check("R4 new whole part used", g, 3);

        // R5: tooth advance restarts the fraction pattern
        write_paused(2, 256);
        wait_tick(g);
        tooth_adv_i = 1'b1;
        step();
        tooth_adv_i = 1'b0;
        wait_tick(g);
        check("R5 gap before clear point", g + 1, 2);
        wait_tick(g);
        check("R5 no carry after clear", g, 2);
        wait_tick(g);
        check("R5 carry on second add", g, 3);

        // R7, R8, R9: high-rate entry, cadence and exit
        write_paused(20, 256);
        wait_tick(g);
        high_rate_i = 1'b1;
        wait_tick(g);
        check("R8 entry gap", g, 9);
        gate = 1'b0;
        for (int k = 0; k < 3; k++) begin
            wait_tick(g);
            check("R7 high-rate spacing without enable", g, 8);
        end
        gate = 1'b1;
        wait_tick(g);
        check("R7 high-rate spacing", g, 8);
        high_rate_i = 1'b0;
        wait_tick(g);
        check("R9 first tick after exit", g, 21);
        wait_tick(g);
        check("R7 no fraction adds in high rate", g, 21);
        wait_tick(g);
        check("R9 pattern after exit", g, 20);

        // R6: pulse is one cycle wide when ticks are spaced
        write_paused(3, 0);
        wait_tick(g);
        step();
        check("R6 single-cycle pulse", tick_o, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule